// File: doc/BRIEF.md
# I2C Dual-Target Slave Front End

This block is the bus-facing half of a two-wire serial target that exposes two storage spaces behind a single bus address family: a general memory array and a bank of clock/control registers. The block runs entirely on a system clock. It resynchronises the serial clock and data lines, recognises START and STOP conditions, and decodes the first byte of each transfer into a target, a direction and a match/no-match decision. It pulls the data line low through an open-drain enable only when it acknowledges or sends a zero bit.

For writes, the block collects a 16-bit word address, high byte first, into a shared address pointer. It then hands each data byte to a storage or commit block as a single-cycle strobe carrying the target, address and data. For reads, it issues a single-cycle request carrying the target and the pointer, and shifts out the byte returned on the read-data input. It supports current-address reads, random reads (an address-only write followed by a repeated START) and sequential reads. A random read is refused when its read phase names a different target from its address phase. A `busy` input from the commit block silences the interface for as long as a nonvolatile write is in progress.

Top module: `i2c_dual_target_slave`

## Requirements
- R1: The first byte after START is acknowledged (data line pulled low during the ninth clock) only when bits 7:1 equal 1010111 (memory array, target 0) or 1101111 (register bank, target 1). Any other value is not acknowledged, and the rest of that transfer is ignored until the next START.
- R2: In a write (byte bit 0 = 0), the two address bytes that follow, high byte first, and every data byte are acknowledged. Each data byte produces one `wr_valid_o` cycle carrying the target, the data, and the address equal to the word address plus the byte's index. A write strobe and a read request never occur in the same cycle.
- R3: The address pointer is 0 after reset, so a current-address read right after reset returns location 0. After reset the data line is released and no strobe is active.
- R4: After every byte written or read, the pointer equals that byte's address plus one. A later current-address read continues from there.
- R5: A random read whose read-phase byte selects the same target as its address phase returns the data at the supplied address. When the targets differ, the read byte is not acknowledged and no read request is issued.
- R6: In a read (byte bit 0 = 1), the master acknowledges each byte to get the next one. If the master leaves the ninth clock unacknowledged, the block releases the data line and issues no further read request until a new START.
- R7: While `busy_i` is high, the data line stays released and no transfer is acknowledged, written or read. After `busy_i` falls, the next START is served normally.
- R8: A START or STOP in the middle of a byte returns the block to idle. A STOP inside a data byte produces no write strobe. A START begins a fresh capture of the first byte.
- R9: The block starts pulling the data line low only while the synchronised serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line (asynchronous) |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| busy_i | input | 1 | Commit block busy; interface silent while high |
| wr_valid_o | output | 1 | One-cycle write strobe |
| wr_target_o | output | 1 | Write target: 0 array, 1 register bank |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | 8 | Write data |
| rd_req_o | output | 1 | One-cycle read request |
| rd_target_o | output | 1 | Read target: 0 array, 1 register bank |
| rd_addr_o | output | ADDR_W | Read address (current pointer) |
| rd_data_i | input | 8 | Read data, valid from the cycle after `rd_req_o` |

## Verification
A stale or wrong pointer shows up at once, in the address of the next write strobe or read request. Because addresses are checked across a 16-bit carry and across target switches, a pointer that loses bits or belongs to the wrong target is caught within one byte. A wrong decode or bit-count state shows up as a wrong acknowledge within the same nine-clock frame: the bench sweeps all 128 address values, random reads with both matching and mismatched targets, and START/STOP conditions cut into a byte. A state machine that fails to return to idle after a NACK, a busy period or an aborted byte shows up on the next transfer as an unexpected strobe or acknowledge.

// File: rtl/i2c_dt_pkg.sv
package i2c_dt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD
  } st_e;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned FRAME_LEN = 9;
  localparam int unsigned CNT_W     = 4;
  localparam logic        TGT_ARRAY = 1'b0;
  localparam logic        TGT_REGS  = 1'b1;
endpackage

// File: rtl/i2c_dt_sync.sv
module i2c_dt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned LINES = 2;
  localparam int unsigned SCL_IX = 1;
  localparam int unsigned SDA_IX = 0;

  logic [LINES-1:0] raw, synced, prev_q;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '1;
      else         ff_q <= {ff_q[STAGES-2:0], raw[g]};
    end
    assign synced[g] = ff_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= synced;
  end

  assign scl_o      = synced[SCL_IX];
  assign sda_o      = synced[SDA_IX];
  assign scl_rise_o = synced[SCL_IX] & ~prev_q[SCL_IX];
  assign scl_fall_o = ~synced[SCL_IX] & prev_q[SCL_IX];
  // data edges while clock stays high
  assign start_o = synced[SCL_IX] & prev_q[SCL_IX] & prev_q[SDA_IX] & ~synced[SDA_IX];
  assign stop_o  = synced[SCL_IX] & prev_q[SCL_IX] & ~prev_q[SDA_IX] & synced[SDA_IX];
endmodule

// File: rtl/i2c_dt_decode.sv
module i2c_dt_decode #(
  parameter logic [3:0] ARRAY_ID = 4'b1010,
  parameter logic [3:0] CCR_ID   = 4'b1101,
  parameter logic [2:0] DEV_SEL  = 3'b111
) (
  input  logic [7:0] byte_i,
  output logic       hit_o,
  output logic       tgt_o,
  output logic       rnw_o
);
  localparam int unsigned N_TGT = 2;
  localparam int unsigned ID_W  = 4;
  localparam logic [N_TGT*ID_W-1:0] IDS = {CCR_ID, ARRAY_ID};

  logic [N_TGT-1:0] id_hit;

  for (genvar g = 0; g < N_TGT; g++) begin : g_id
    assign id_hit[g] = (byte_i[7:4] == IDS[g*ID_W +: ID_W]);
  end

  assign hit_o = (|id_hit) && (byte_i[3:1] == DEV_SEL);
  assign tgt_o = id_hit[1];
  assign rnw_o = byte_i[0];
endmodule

// File: rtl/i2c_dt_ptr.sv
module i2c_dt_ptr #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  input  logic              pend_set_i,
  input  logic              pend_tgt_i,
  input  logic              pend_clr_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              pend_o,
  output logic              pend_tgt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (inc_i)  ptr_o <= ptr_o + 1'b1;
  end

  // address-only write awaiting a repeated START
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o     <= 1'b0;
      pend_tgt_o <= 1'b0;
    end else if (pend_clr_i) begin
      pend_o <= 1'b0;
    end else if (pend_set_i) begin
      pend_o     <= 1'b1;
      pend_tgt_o <= pend_tgt_i;
    end
  end
endmodule

// File: rtl/i2c_dual_target_slave.sv
module i2c_dual_target_slave
  import i2c_dt_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [3:0]  ARRAY_ID    = 4'b1010,
  parameter logic [3:0]  CCR_ID      = 4'b1101,
  parameter logic [2:0]  DEV_SEL     = 3'b111
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              busy_i,
  output logic              wr_valid_o,
  output logic              wr_target_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              rd_req_o,
  output logic              rd_target_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i
);
  localparam int unsigned WORD_W = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] END_SLOT = CNT_W'(FRAME_LEN);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  st_e               state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rx_q, tx_q, ahi_q;
  logic              sda_oe_q, ack_q, rnw_q, mack_q, tgt_q;
  logic              wr_valid_q, rd_req_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [BYTE_W-1:0] wr_data_q;

  logic              dec_hit, dec_tgt, dec_rnw, dev_ack;
  logic [ADDR_W-1:0] ptr;
  logic              pend, pend_tgt;
  logic              quiet, fall_ack, ptr_load, ptr_inc, pend_clr;
  logic [WORD_W-1:0] word;

  i2c_dt_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_dt_decode #(
    .ARRAY_ID (ARRAY_ID),
    .CCR_ID   (CCR_ID),
    .DEV_SEL  (DEV_SEL)
  ) i_decode (
    .byte_i (rx_q),
    .hit_o  (dec_hit),
    .tgt_o  (dec_tgt),
    .rnw_o  (dec_rnw)
  );

  // read phase must name the target of a pending address-only write
  assign dev_ack = dec_hit && !(dec_rnw && pend && (pend_tgt != dec_tgt));

  assign quiet    = busy_i || start_det || stop_det;
  assign fall_ack = !quiet && scl_fall && (cnt_q == ACK_SLOT);
  assign ptr_load = fall_ack && (state_q == ST_ALO);
  assign ptr_inc  = fall_ack && ((state_q == ST_WR) || (state_q == ST_RD));
  assign pend_clr = busy_i || stop_det ||
                    (fall_ack && ((state_q == ST_DEV) || (state_q == ST_WR)));
  assign word     = {ahi_q, rx_q};

  i2c_dt_ptr #(.ADDR_W(ADDR_W)) i_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ptr_load),
    .load_val_i (word[ADDR_W-1:0]),
    .inc_i      (ptr_inc),
    .pend_set_i (ptr_load),
    .pend_tgt_i (tgt_q),
    .pend_clr_i (pend_clr),
    .ptr_o      (ptr),
    .pend_o     (pend),
    .pend_tgt_o (pend_tgt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      ahi_q      <= '0;
      sda_oe_q   <= 1'b0;
      ack_q      <= 1'b0;
      rnw_q      <= 1'b0;
      mack_q     <= 1'b0;
      tgt_q      <= TGT_ARRAY;
      wr_valid_q <= 1'b0;
      rd_req_q   <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
    end else begin
      wr_valid_q <= 1'b0;
      rd_req_q   <= 1'b0;
      if (busy_i || stop_det) begin
        state_q  <= ST_IDLE;
        cnt_q    <= '0;
        sda_oe_q <= 1'b0;
      end else if (start_det) begin
        state_q  <= ST_DEV;
        cnt_q    <= '0;
        sda_oe_q <= 1'b0;
      end else if (state_q != ST_IDLE) begin
        if (scl_rise) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q < ACK_SLOT && state_q != ST_RD) rx_q <= {rx_q[BYTE_W-2:0], sda_s};
          if (cnt_q == ACK_SLOT && state_q == ST_RD) begin
            mack_q <= !sda_s;
            if (!sda_s) rd_req_q <= 1'b1;
          end
        end
        if (scl_fall) begin
          if (cnt_q == ACK_SLOT) begin
            unique case (state_q)
              ST_DEV: begin
                sda_oe_q <= dev_ack;
                ack_q    <= dev_ack;
                if (dev_ack) begin
                  tgt_q <= dec_tgt;
                  rnw_q <= dec_rnw;
                  if (dec_rnw) rd_req_q <= 1'b1;
                end
              end
              ST_AHI: begin
                sda_oe_q <= 1'b1;
                ahi_q    <= rx_q;
              end
              ST_ALO: sda_oe_q <= 1'b1;
              ST_WR: begin
                sda_oe_q   <= 1'b1;
                wr_valid_q <= 1'b1;
                wr_addr_q  <= ptr;
                wr_data_q  <= rx_q;
              end
              ST_RD:  sda_oe_q <= 1'b0;
              default: ;
            endcase
          end else if (cnt_q == END_SLOT) begin
            cnt_q    <= '0;
            sda_oe_q <= 1'b0;
            unique case (state_q)
              ST_DEV: begin
                if (!ack_q) state_q <= ST_IDLE;
                else if (rnw_q) begin
                  state_q  <= ST_RD;
                  tx_q     <= rd_data_i;
                  sda_oe_q <= ~rd_data_i[BYTE_W-1];
                end else state_q <= ST_AHI;
              end
              ST_AHI: state_q <= ST_ALO;
              ST_ALO: state_q <= ST_WR;
              ST_WR:  state_q <= ST_WR;
              ST_RD: begin
                if (mack_q) begin
                  tx_q     <= rd_data_i;
                  sda_oe_q <= ~rd_data_i[BYTE_W-1];
                end else state_q <= ST_IDLE;
              end
              default: state_q <= ST_IDLE;
            endcase
          end else if (state_q == ST_RD && cnt_q != '0) begin
            tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
            sda_oe_q <= ~tx_q[BYTE_W-2];
          end
        end
      end
    end
  end

  assign sda_oe_o    = sda_oe_q;
  assign wr_valid_o  = wr_valid_q;
  assign wr_target_o = tgt_q;
  assign wr_addr_o   = wr_addr_q;
  assign wr_data_o   = wr_data_q;
  assign rd_req_o    = rd_req_q;
  assign rd_target_o = tgt_q;
  assign rd_addr_o   = ptr;

  AST_BUSY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (!sda_oe_q && !wr_valid_q && !rd_req_q)); // R7

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_q) |-> !scl_s); // R9

  AST_PTR_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_q |-> (ptr == ADDR_W'(wr_addr_q + 1'b1))); // R4

  AST_RR_SAME_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_q && $past(pend)) |-> (rd_target_o == $past(pend_tgt))); // R5

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_valid_q && rd_req_q)); // R2
endmodule

// File: tb/test_i2c_dual_target_slave.sv
module test_i2c_dual_target_slave;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic sda_line;
  logic sda_oe, wr_valid, wr_tgt, rd_req, rd_tgt;
  logic [15:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  int n_tests = 0, n_fail = 0;
  int wl_n = 0, rd_n = 0, viol = 0;
  logic [15:0] wl_addr [32];
  logic [7:0]  wl_data [32];
  logic        wl_tgt  [32];
  logic        prev_oe = 1'b0;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  function automatic logic [7:0] mem_f(input logic t, input logic [15:0] a);
    return (a[7:0] * 8'd7 + a[15:8]) ^ (t ? 8'hA5 : 8'h00);
  endfunction

  assign rd_data = mem_f(rd_tgt, rd_addr);

  i2c_dual_target_slave i_i2c_dual_target_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .busy_i(busy),
    .wr_valid_o(wr_valid), .wr_target_o(wr_tgt), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_req_o(rd_req), .rd_target_o(rd_tgt), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  always @(posedge clk) begin
    if (wr_valid && wl_n < 32) begin
      wl_addr[wl_n] = wr_addr;
      wl_data[wl_n] = wr_data;
      wl_tgt[wl_n]  = wr_tgt;
      wl_n++;
    end
    if (rd_req) rd_n++;
    if (sda_oe && !prev_oe && scl_m) viol++;
    prev_oe = sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(Q);
  endtask

  task automatic wbit(input logic b);
    sda_m = b; wt(Q);
    scl_m = 1'b1; wt(2 * Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    b = sda_line; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(x);
    ack = !x;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic mack);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      rbit(x);
      v[i] = x;
    end
    wbit(!mack);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int base_rd, base_wl;
    logic [7:0] wdat [5];
    wdat[0] = 8'h3C; wdat[1] = 8'hC3; wdat[2] = 8'h5A; wdat[3] = 8'h11; wdat[4] = 8'h22;

    wt(5);
    rst_n = 1'b1;
    wt(5);
    // R3 reset state
    check(!sda_oe && !wr_valid && !rd_req, "R3 reset outputs", {sda_oe, wr_valid, rd_req}, 0);

    // R3 current-address read after reset -> location 0
    bus_start();
    send_byte(8'hAF, ack);
    check(ack, "R3 ack read byte", ack, 1);
    recv_byte(d, 1'b0);
    check(d == mem_f(0, 16'h0000), "R3 data at 0", d, mem_f(0, 16'h0000));
    bus_stop();

    // R1 sweep over all 7-bit values, write direction
    for (int a = 0; a < 128; a++) begin
      logic [6:0] av;
      logic exp_ack;
      av = 7'(a);
      exp_ack = (av[6:3] == 4'b1010 || av[6:3] == 4'b1101) && av[2:0] == 3'b111;
      bus_start();
      send_byte({av, 1'b0}, ack);
      check(ack == exp_ack, "R1 address match", ack, exp_ack);
      bus_stop();
    end

    // R1 byte after a refused address byte is ignored
    bus_start();
    send_byte(8'hA2, ack);
    check(!ack, "R1 bad address nack", ack, 0);
    send_byte(8'h00, ack);
    check(!ack, "R1 following byte ignored", ack, 0);
    bus_stop();
    check(wl_n == 0 && rd_n == 1, "R1 no strobes", wl_n, 0);

    // R2 array write at 0x1234
    bus_start();
    send_byte(8'hAE, ack); check(ack, "R2 ack slave", ack, 1);
    send_byte(8'h12, ack); check(ack, "R2 ack addr hi", ack, 1);
    send_byte(8'h34, ack); check(ack, "R2 ack addr lo", ack, 1);
    for (int i = 0; i < 3; i++) begin
      send_byte(wdat[i], ack); check(ack, "R2 ack data", ack, 1);
    end
    bus_stop();
    // R2 register-bank write at 0x0005
    bus_start();
    send_byte(8'hDE, ack); check(ack, "R2 ack ccr slave", ack, 1);
    send_byte(8'h00, ack);
    send_byte(8'h05, ack);
    for (int i = 3; i < 5; i++) begin
      send_byte(wdat[i], ack); check(ack, "R2 ack ccr data", ack, 1);
    end
    bus_stop();
    check(wl_n == 5, "R2 write count", wl_n, 5);
    for (int i = 0; i < 5; i++) begin
      logic [15:0] ea;
      logic et;
      ea = (i < 3) ? 16'(16'h1234 + i) : 16'(16'h0005 + i - 3);
      et = (i >= 3);
      check(wl_addr[i] == ea, "R2 write addr", wl_addr[i], ea);
      check(wl_data[i] == wdat[i], "R2 write data", wl_data[i], wdat[i]);
      check(wl_tgt[i] == et, "R2 write target", wl_tgt[i], et);
    end

    // R4 current-address read after the bank write -> 0x0007
    bus_start();
    send_byte(8'hDF, ack); check(ack, "R4 ack ccr read", ack, 1);
    recv_byte(d, 1'b0);
    check(d == mem_f(1, 16'h0007), "R4 ptr after write", d, mem_f(1, 16'h0007));
    bus_stop();

    // R5 random read with carry across 0x00FF, sequential 4 bytes
    base_rd = rd_n;
    bus_start();
    send_byte(8'hAE, ack);
    send_byte(8'h00, ack);
    send_byte(8'hFE, ack);
    bus_start();
    send_byte(8'hAF, ack); check(ack, "R5 ack matching target", ack, 1);
    for (int i = 0; i < 4; i++) begin
      logic [15:0] ea;
      ea = 16'(16'h00FE + i);
      recv_byte(d, i < 3);
      check(d == mem_f(0, ea), "R4 sequential data", d, mem_f(0, ea));
    end
    wt(4 * Q);
    check(!sda_oe, "R6 released after master nack", sda_oe, 0);
    check(rd_n - base_rd == 4, "R6 request count", rd_n - base_rd, 4);
    bus_stop();

    // R4 continue from 0x0102
    bus_start();
    send_byte(8'hAF, ack);
    recv_byte(d, 1'b0);
    check(d == mem_f(0, 16'h0102), "R4 current after sequential", d, mem_f(0, 16'h0102));
    bus_stop();

    // R5 mismatched target
    base_rd = rd_n;
    bus_start();
    send_byte(8'hAE, ack);
    send_byte(8'h00, ack);
    send_byte(8'h10, ack);
    bus_start();
    send_byte(8'hDF, ack);
    check(!ack, "R5 mismatch nack", ack, 0);
    bus_stop();
    check(rd_n == base_rd, "R5 mismatch no request", rd_n - base_rd, 0);

    // R7 busy
    base_wl = wl_n;
    busy = 1'b1;
    bus_start();
    send_byte(8'hAE, ack);
    check(!ack, "R7 busy nack", ack, 0);
    send_byte(8'h00, ack);
    send_byte(8'h00, ack);
    send_byte(8'h99, ack);
    bus_stop();
    check(wl_n == base_wl && rd_n == base_rd, "R7 busy no strobes", wl_n - base_wl, 0);
    busy = 1'b0;
    wt(Q);
    bus_start();
    send_byte(8'hAE, ack);
    check(ack, "R7 served after busy", ack, 1);
    bus_stop();

    // R8 STOP inside a data byte
    bus_start();
    send_byte(8'hAE, ack);
    send_byte(8'h00, ack);
    send_byte(8'h40, ack);
    for (int i = 0; i < 4; i++) wbit(1'b1);
    bus_stop();
    check(wl_n == base_wl, "R8 partial byte not written", wl_n - base_wl, 0);
    bus_start();
    send_byte(8'hAF, ack);
    recv_byte(d, 1'b0);
    check(d == mem_f(0, 16'h0040), "R8 ptr after aborted write", d, mem_f(0, 16'h0040));
    bus_stop();

    // R8 START inside an address byte
    bus_start();
    send_byte(8'hAE, ack);
    for (int i = 0; i < 4; i++) wbit(i[0]);
    bus_start();
    send_byte(8'hAF, ack);
    check(ack, "R8 fresh capture after start", ack, 1);
    recv_byte(d, 1'b0);
    check(d == mem_f(0, 16'h0041), "R8 data after restart", d, mem_f(0, 16'h0041));
    bus_stop();
    wt(Q);

    check(viol == 0, "R9 drive only with clock low", viol, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule